// File: doc/BRIEF.md
# Byte-Lane I/O-Mapped Output Port

This block is a 16-bit parallel output port that sits on a processor's I/O bus. The I/O space is 256 bytes wide, so only the low eight address bits are compared. When the port address shows up together with an active-low write strobe, the port captures data-bus bytes into two 8-bit holding registers. Those registers drive a 16-bit peripheral output, such as a row of LEDs.

The lane mapping is big-endian. The register at the even address DEh takes data lines 15..8 and drives output bits 15..8. The register at the odd address DFh takes data lines 7..0 and drives output bits 7..0.

A compile-time parameter picks one of two decode modes:

- **Word-only mode.** The full low address byte must equal DEh. Both byte registers then load together.
- **Byte-lane mode.** Address bit 0 is removed from the shared match. Bit 0 then chooses which one register loads, so each byte can be written on its own.

Top module: `io_byte_port`

## Requirements
- R1: Only address bits 7..0 take part in the decode. Bits 15..8 have no effect on whether a write is accepted, and a difference in any of bits 7..1 from DEh blocks the write.
- R2: With the write strobe `wr_n_i` high (inactive), no register loads and `port_o` holds its value.
- R3: In word-only mode, a write to DEh with `wr_n_i` low loads `data_i` into `port_o`. The new value is visible after the rising clock edge at which the decode is true.
- R4: In word-only mode, the two register enables are always equal. A write to DFh or E0h leaves `port_o` unchanged.
- R5: The lane mapping is big-endian: data lines 15..8 belong to the even address and drive `port_o[15:8]`. A word write of 1234h drives output bits 12, 9, 5, 4 and 2 high and every other bit low.
- R6: In byte-lane mode, a write to DEh loads only `port_o[15:8]`, from `data_i[15:8]`. At most one register enable is active at a time.
- R7: In byte-lane mode, a write to DFh loads only `port_o[7:0]`, from `data_i[7:0]`.
- R8: In byte-lane mode, writes to addresses outside DEh/DFh (for example DCh, E0h) leave `port_o` unchanged.
- R9: The synchronous active-high reset `rst` clears `port_o` to 0000h on the next clock edge, and it takes priority over a write in the same cycle.
- R10: Each register keeps its value on every clock edge at which its enable is false.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 16 | I/O address bus (bits 15..8 ignored) |
| data_i | input | 16 | Data bus from the processor |
| wr_n_i | input | 1 | Active-low I/O write strobe |
| port_o | output | 16 | Registered peripheral output |

## Verification
The bench builds two instances side by side, both with base address DEh. One uses the default word-only mode and the other uses byte-lane mode. Both instances receive the same stimulus, so the same bus cycle can be checked against the two decode variants. This makes it possible to see that DFh loads nothing in one mode and only the low lane in the other. It also shows that a DEh write fills the whole word in word-only mode but only the upper lane in byte-lane mode.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  localparam int LANE_BITS = 8;

  typedef enum logic {
    DEC_WORD = 1'b0,
    DEC_LANE = 1'b1
  } dec_mode_e;
endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode #(
  parameter int                    DEC_W     = 8,
  parameter int                    NUM_LANES = 2,
  parameter logic [DEC_W-1:0]      BASE_ADDR = 8'hDE,
  parameter io_port_pkg::dec_mode_e MODE     = io_port_pkg::DEC_WORD
) (
  input  logic [DEC_W-1:0]     addr,
  input  logic                 wr_n,
  output logic [NUM_LANES-1:0] lane_en
);
  localparam int SEL_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic hit;

  generate
    if (MODE == io_port_pkg::DEC_WORD) begin : g_word
      // full byte compare, strobe qualifies the single shared match
      assign hit     = (addr == BASE_ADDR) && !wr_n;
      assign lane_en = {NUM_LANES{hit}};
    end else begin : g_lane
      // low select bits leave the shared match and steer the lanes
      assign hit = (addr[DEC_W-1:SEL_W] == BASE_ADDR[DEC_W-1:SEL_W]) && !wr_n;
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_en
        // big-endian: lane NUM_LANES-1 (upper data lines) at offset 0
        localparam logic [SEL_W-1:0] OFFS = SEL_W'(NUM_LANES - 1 - i);
        assign lane_en[i] = hit && (addr[SEL_W-1:0] == (BASE_ADDR[SEL_W-1:0] + OFFS));
      end
    end
  endgenerate
endmodule

// File: rtl/io_lane_reg.sv
module io_lane_reg #(
  parameter int W = io_port_pkg::LANE_BITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  p_reset_r9: assert property (@(posedge clk) rst |=> (q == '0))
    else $error("lane register not cleared by reset");
  p_load_r3: assert property (@(posedge clk) disable iff (rst) en |=> (q == $past(d)))
    else $error("lane register did not capture bus data");
  p_hold_r10: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(q))
    else $error("lane register changed without enable");
endmodule

// File: rtl/io_byte_port.sv
module io_byte_port #(
  parameter int                     ADDR_W    = 16,
  parameter int                     DATA_W    = 16,
  parameter int                     DEC_W     = 8,
  parameter logic [7:0]             BASE_ADDR = 8'hDE,
  parameter io_port_pkg::dec_mode_e MODE      = io_port_pkg::DEC_WORD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wr_n_i,
  output logic [DATA_W-1:0] port_o
);
  localparam int LB        = io_port_pkg::LANE_BITS;
  localparam int NUM_LANES = DATA_W / LB;

  logic [NUM_LANES-1:0] lane_en;
  logic                 unused_hi;

  // upper address lines are outside the 256-byte I/O space
  assign unused_hi = ^addr_i[ADDR_W-1:DEC_W];

  io_addr_decode #(
    .DEC_W    (DEC_W),
    .NUM_LANES(NUM_LANES),
    .BASE_ADDR(DEC_W'(BASE_ADDR)),
    .MODE     (MODE)
  ) u_dec (
    .addr   (addr_i[DEC_W-1:0]),
    .wr_n   (wr_n_i),
    .lane_en(lane_en)
  );

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      io_lane_reg #(.W(LB)) u_reg (
        .clk(clk),
        .rst(rst),
        .en (lane_en[i]),
        .d  (data_i[i*LB +: LB]),
        .q  (port_o[i*LB +: LB])
      );
    end
  endgenerate

  p_strobe_r2: assert property (@(posedge clk) disable iff (rst) wr_n_i |-> (lane_en == '0))
    else $error("lane enabled without write strobe");

  generate
    if (MODE == io_port_pkg::DEC_WORD) begin : g_chk_word
      p_word_en_r4: assert property (@(posedge clk) disable iff (rst)
                                     (lane_en == '0) || (lane_en == '1))
        else $error("word mode lane enables differ");
    end else begin : g_chk_lane
      p_one_lane_r6: assert property (@(posedge clk) disable iff (rst) $onehot0(lane_en))
        else $error("byte-lane mode enabled more than one lane");
    end
  endgenerate
endmodule

// File: tb/tb_io_byte_port.sv
`timescale 1ns/1ps
module tb_io_byte_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [15:0] data = '0;
  logic        wr_n = 1'b1;
  logic [15:0] q_word, q_lane;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  io_byte_port #(.MODE(io_port_pkg::DEC_WORD)) dut (
    .clk(clk), .rst(rst), .addr_i(addr), .data_i(data), .wr_n_i(wr_n), .port_o(q_word));

  io_byte_port #(.MODE(io_port_pkg::DEC_LANE)) dut_lane (
    .clk(clk), .rst(rst), .addr_i(addr), .data_i(data), .wr_n_i(wr_n), .port_o(q_lane));

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] d;
    logic        wn;
    logic [15:0] exp_w;
    logic [15:0] exp_l;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h00DE, 16'h1234, 1'b0, 16'h1234, 16'h1200, 8'd3}, // R3 word load, R6 upper lane only
    '{16'h00DF, 16'hABCD, 1'b0, 16'h1234, 16'h12CD, 8'd7}, // R4 no load in word, R7 low lane
    '{16'h00E0, 16'hFFFF, 1'b0, 16'h1234, 16'h12CD, 8'd8}, // R4 / R8 E0h ignored
    '{16'hFFDE, 16'h5A5A, 1'b1, 16'h1234, 16'h12CD, 8'd2}, // R2 strobe high
    '{16'h12DE, 16'h8001, 1'b0, 16'h8001, 16'h80CD, 8'd1}, // R1 upper address bits ignored
    '{16'h00DC, 16'h1111, 1'b0, 16'h8001, 16'h80CD, 8'd8}, // R8 DCh ignored
    '{16'hABDF, 16'h0077, 1'b0, 16'h8001, 16'h8077, 8'd7}, // R1 / R7 low lane with junk high addr
    '{16'h005E, 16'h2222, 1'b0, 16'h8001, 16'h8077, 8'd1}, // R1 bit 7 mismatch blocks
    '{16'h00DE, 16'h0000, 1'b0, 16'h0000, 16'h0077, 8'd10} // R10 other lane holds
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [15:0] a, input logic [15:0] d, input logic wn);
    @(negedge clk);
    addr = a; data = d; wr_n = wn;
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 reset word", q_word, 16'h0000);
    chk("R9 reset lane", q_lane, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      bus_cycle(VECS[i].a, VECS[i].d, VECS[i].wn);
      chk($sformatf("R%0d vec%0d word", VECS[i].req, i), q_word, VECS[i].exp_w);
      chk($sformatf("R%0d vec%0d lane", VECS[i].req, i), q_lane, VECS[i].exp_l);
    end

    // R5 big-endian bit positions of 1234h
    bus_cycle(16'h00DE, 16'h1234, 1'b0);
    chk("R5 bits high", {11'd0, q_word[12], q_word[9], q_word[5], q_word[4], q_word[2]}, 16'h001F);
    chk("R5 popcount", 16'($countones(q_word)), 16'd5);

    // R7 then R6 rebuild full word in lane mode
    bus_cycle(16'h00DF, 16'h0034, 1'b0);
    chk("R7 low lane", q_lane, 16'h1234);
    chk("R4 word DFh hold", q_word, 16'h1234);

    // R9 reset beats a simultaneous write
    @(negedge clk);
    rst = 1'b1; addr = 16'h00DE; data = 16'hFFFF; wr_n = 1'b0;
    @(negedge clk);
    rst = 1'b0; wr_n = 1'b1;
    chk("R9 reset priority word", q_word, 16'h0000);
    chk("R9 reset priority lane", q_lane, 16'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule